// File: doc/BRIEF.md
# Decimal Digit Adder

This block adds two binary-coded decimal digits and an incoming decade carry in one purely combinational pass. The two digits and the carry are first summed as ordinary binary numbers into a five-bit intermediate value between 0 and 19. A correction stage then detects totals of ten or more, raises the decade carry, and adds six to the low nibble so that the digit leaves the block as one of the ten legal codes.

Several copies chain through their carry pins to add decimal numbers of any length. The least significant copy takes the external carry-in, and each carry-out feeds the next more significant copy. A separate flag reports whether either operand holds one of the six codes that no decimal digit uses. While that flag is high, the digit and carry outputs carry no meaning. A parameter selects how the binary carries are formed: either a rippled chain of full adders or flat generate/propagate lookahead terms.

Top module: `bcd_digit_adder`

## Requirements
- R1: Digits use the weighted 8-4-2-1 code, so decimal 0..9 is 4'b0000..4'b1001. For legal operands, sum_dig + 10*c_out equals a_dig + b_dig + c_in.
- R2: For legal operands, sum_dig never holds any of the codes 4'b1010..4'b1111.
- R3: For legal operands, c_out is 1 exactly when a_dig + b_dig + c_in is 10 or more, which is when the binary carry is set or the low binary nibble is 4'b1010 or above.
- R4: When c_out is 0, sum_dig equals the plain binary sum a_dig + b_dig + c_in.
- R5: When c_out is 1, sum_dig equals the low four bits of (a_dig + b_dig + c_in + 6). The carry out of that correction addition is discarded.
- R6: bad_code is 1 exactly when a_dig or b_dig lies in 4'b1010..4'b1111, whatever the value of c_in.
- R7: The ripple variant (LOOKAHEAD=0) and the lookahead variant (LOOKAHEAD=1) give identical sum_dig, c_out and bad_code for every input.
- R8: Four copies, each c_out wired to the next copy's c_in, add two four-digit decimal numbers. The result is the four-digit decimal sum, and the top copy's c_out is the ten-thousands digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_dig | input | 4 | First operand digit, 8-4-2-1 code |
| b_dig | input | 4 | Second operand digit, 8-4-2-1 code |
| c_in | input | 1 | Carry from the less significant decade |
| sum_dig | output | 4 | Corrected decimal sum digit |
| c_out | output | 1 | Carry to the more significant decade |
| bad_code | output | 1 | High when either operand is not a decimal code |

## Verification
All 200 legal combinations of the two digits and the carry-in are applied. This separates totals below ten, where no correction may occur, from totals of ten through fifteen, where only the nibble comparison triggers the carry. It also separates totals of sixteen through nineteen, where the binary carry triggers it. Randomly drawn operands that mix forbidden and legal codes show that the flag depends only on the operand codes and not on the carry-in. A ripple instance and a lookahead instance receive the same stimulus, so any divergence between the two carry variants is exposed. Random and directed four-digit cascades, such as 9999+0001 with and without the initial carry, check that the decade carry travels the full length of a chain.

// File: rtl/bcdadd_pkg.sv
package bcdadd_pkg;
   localparam int unsigned DIGIT_W   = 4;
   localparam int unsigned RAW_W     = DIGIT_W + 1;
   localparam int unsigned MAX_DIGIT = 9;
   localparam int unsigned FIX_VALUE = 6;

   typedef logic [DIGIT_W-1:0] digit_t;
   typedef logic [RAW_W-1:0]   raw_t;

   function automatic logic is_forbidden(input digit_t d);
      return (d > digit_t'(MAX_DIGIT));
   endfunction
endpackage

// File: rtl/bcdadd_bin_sum.sv
module bcdadd_bin_sum #(
   parameter int unsigned W         = 4,
   parameter bit          LOOKAHEAD = 1'b1
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         cin,
   output logic [W:0]   raw
);
   localparam int unsigned NC = W + 1;

   logic [W-1:0]  gen_v;
   logic [W-1:0]  prop_v;
   logic [NC-1:0] carry_v;

   assign gen_v  = op_a & op_b;
   assign prop_v = op_a ^ op_b;

   generate
      if (LOOKAHEAD) begin : g_lookahead
         always_comb begin
            carry_v[0] = cin;
            for (int i = 0; i < W; i++) begin
               logic term;
               logic chain;
               chain = cin;
               for (int k = 0; k <= i; k++) chain = chain & prop_v[k];
               term = chain;
               for (int j = 0; j <= i; j++) begin
                  logic prod;
                  prod = gen_v[j];
                  for (int k = j + 1; k <= i; k++) prod = prod & prop_v[k];
                  term = term | prod;
               end
               carry_v[i+1] = term;
            end
         end
      end else begin : g_ripple
         assign carry_v[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_stage
            assign carry_v[i+1] = gen_v[i] | (prop_v[i] & carry_v[i]);
         end
      end
   endgenerate

   assign raw = {carry_v[W], prop_v ^ carry_v[W-1:0]};
endmodule

// File: rtl/bcdadd_fix.sv
module bcdadd_fix
   import bcdadd_pkg::*;
(
   input  raw_t   raw,
   output digit_t digit,
   output logic   dec_carry
);
   localparam digit_t ADJ = digit_t'(FIX_VALUE);

   logic nib_high;

   // low nibble at or above ten: bit 3 set together with bit 2 or bit 1
   assign nib_high  = raw[DIGIT_W-1] & (raw[DIGIT_W-2] | raw[DIGIT_W-3]);
   assign dec_carry = raw[DIGIT_W] | nib_high;
   assign digit     = raw[DIGIT_W-1:0] + (dec_carry ? ADJ : digit_t'(0));
endmodule

// File: rtl/bcdadd_code_chk.sv
module bcdadd_code_chk
   import bcdadd_pkg::*;
(
   input  digit_t a_dig,
   input  digit_t b_dig,
   output logic   bad
);
   logic [1:0] bad_each;

   always_comb begin
      bad_each[0] = is_forbidden(a_dig);
      bad_each[1] = is_forbidden(b_dig);
   end

   assign bad = |bad_each;
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
   import bcdadd_pkg::*;
#(
   parameter int unsigned DIGIT_BITS = 4,
   parameter bit          LOOKAHEAD  = 1'b1
) (
   input  logic [3:0] a_dig,
   input  logic [3:0] b_dig,
   input  logic       c_in,
   output logic [3:0] sum_dig,
   output logic       c_out,
   output logic       bad_code
);
   generate
      if (DIGIT_BITS != DIGIT_W) begin : g_bad_width
         $fatal(1, "bcd_digit_adder: DIGIT_BITS must be 4");
      end
   endgenerate

   raw_t raw_sum;

   bcdadd_bin_sum #(
      .W         (DIGIT_W),
      .LOOKAHEAD (LOOKAHEAD)
   ) u_bin (
      .op_a (a_dig),
      .op_b (b_dig),
      .cin  (c_in),
      .raw  (raw_sum)
   );

   bcdadd_fix u_fix (
      .raw       (raw_sum),
      .digit     (sum_dig),
      .dec_carry (c_out)
   );

   bcdadd_code_chk u_chk (
      .a_dig (a_dig),
      .b_dig (b_dig),
      .bad   (bad_code)
   );
endmodule

// File: rtl/bcdadd_sva.sv
module bcdadd_sva (
   input logic [3:0] a_dig,
   input logic [3:0] b_dig,
   input logic       c_in,
   input logic [3:0] sum_dig,
   input logic       c_out,
   input logic       bad_code
);
   logic [4:0] total;
   logic       legal;

   assign total = 5'(a_dig) + 5'(b_dig) + 5'(c_in);
   assign legal = (a_dig <= 4'd9) && (b_dig <= 4'd9);

   always_comb begin
      if (legal) begin
         AST_DECIMAL_VALUE: assert ((5'(sum_dig) + (c_out ? 5'd10 : 5'd0)) == total); // R1
         AST_DIGIT_LEGAL:   assert (sum_dig <= 4'd9); // R2
         AST_CARRY_RULE:    assert (c_out == (total >= 5'd10)); // R3
         AST_NO_FIX_PASS:   assert (c_out || (sum_dig == total[3:0])); // R4
      end
      AST_FLAG_CODES: assert (bad_code == ((a_dig > 4'd9) || (b_dig > 4'd9))); // R6
   end
endmodule

bind bcd_digit_adder bcdadd_sva i_bcdadd_sva (
   .a_dig    (a_dig),
   .b_dig    (b_dig),
   .c_in     (c_in),
   .sum_dig  (sum_dig),
   .c_out    (c_out),
   .bad_code (bad_code)
);

// File: tb/test_bcd_digit_adder.sv
module test_bcd_digit_adder;
   localparam int CLK_PERIOD = 10;
   localparam int NDIG       = 4;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [3:0] a_dig, b_dig;
   logic       c_in;
   logic [3:0] sum_la, sum_rp;
   logic       co_la, co_rp, bad_la, bad_rp;

   bcd_digit_adder #(.LOOKAHEAD(1'b1)) i_bcd_digit_adder (
      .a_dig(a_dig), .b_dig(b_dig), .c_in(c_in),
      .sum_dig(sum_la), .c_out(co_la), .bad_code(bad_la));

   bcd_digit_adder #(.LOOKAHEAD(1'b0)) i_bcd_digit_adder_rp (
      .a_dig(a_dig), .b_dig(b_dig), .c_in(c_in),
      .sum_dig(sum_rp), .c_out(co_rp), .bad_code(bad_rp));

   // four-digit cascade
   logic [4*NDIG-1:0] ca, cb, cs;
   logic              c0;
   logic [NDIG:0]     cc;
   logic [NDIG-1:0]   cbad;
   assign cc[0] = c0;
   for (genvar d = 0; d < NDIG; d++) begin : g_casc
      bcd_digit_adder i_dig (
         .a_dig(ca[4*d +: 4]), .b_dig(cb[4*d +: 4]), .c_in(cc[d]),
         .sum_dig(cs[4*d +: 4]), .c_out(cc[d+1]), .bad_code(cbad[d]));
   end

   function automatic int dec_of(input logic [4*NDIG-1:0] v);
      int r = 0;
      for (int d = NDIG-1; d >= 0; d--) r = r*10 + int'(v[4*d +: 4]);
      return r;
   endfunction

   function automatic logic [4*NDIG-1:0] bcd_of(input int n);
      logic [4*NDIG-1:0] r = '0;
      int m = n;
      for (int d = 0; d < NDIG; d++) begin
         r[4*d +: 4] = 4'(m % 10);
         m = m / 10;
      end
      return r;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s a=%0d b=%0d c=%0d actual=%0d expected=%0d",
                  req, a_dig, b_dig, c_in, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic c);
      @(negedge clk);
      a_dig = a; b_dig = b; c_in = c;
      #1;
   endtask

   task automatic check_digit(input logic [3:0] a, input logic [3:0] b, input logic c);
      int tot;
      apply(a, b, c);
      tot = int'(a) + int'(b) + int'(c);
      if (a <= 9 && b <= 9) begin
         chk("R1", int'(sum_la) + 10*int'(co_la), tot);
         chk("R2", int'(sum_la <= 4'd9), 1);
         chk("R3", int'(co_la), int'(tot >= 10));
         if (tot < 10) chk("R4", int'(sum_la), tot);
         else          chk("R5", int'(sum_la), (tot + 6) % 16);
         chk("R6", int'(bad_la), 0);
      end else begin
         chk("R6", int'(bad_la), 1);
      end
      chk("R7", {28'd0, sum_rp, co_rp, bad_rp}, {28'd0, sum_la, co_la, bad_la});
   endtask

   task automatic check_casc(input int x, input int y, input logic c);
      @(negedge clk);
      ca = bcd_of(x); cb = bcd_of(y); c0 = c;
      #1;
      n_run++;
      if (dec_of(cs) + 10000*int'(cc[NDIG]) != x + y + int'(c) || cbad != '0) begin
         n_fail++;
         $display("FAIL R8 %0d+%0d+%0d actual=%0d expected=%0d",
                  x, y, c, dec_of(cs) + 10000*int'(cc[NDIG]), x + y + int'(c));
      end
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int seed = 32'h5eed_0b1d;
      a_dig = '0; b_dig = '0; c_in = 1'b0;
      ca = '0; cb = '0; c0 = 1'b0;
      void'($urandom(seed));
      // initial state with zero inputs
      apply(4'd0, 4'd0, 1'b0);
      chk("R1", int'(sum_la) + 10*int'(co_la), 0);
      chk("R6", int'(bad_la), 0);
      // exhaustive legal space (R1..R5, R7)
      for (int a = 0; a < 10; a++)
         for (int b = 0; b < 10; b++)
            for (int c = 0; c < 2; c++)
               check_digit(4'(a), 4'(b), 1'(c));
      // directed forbidden codes at both edges, R6
      check_digit(4'd10, 4'd0, 1'b0);
      check_digit(4'd0, 4'd15, 1'b1);
      check_digit(4'd9, 4'd10, 1'b1);
      // random incl. forbidden codes, R6/R7
      for (int i = 0; i < 300; i++)
         check_digit(4'($urandom_range(15)), 4'($urandom_range(15)), 1'($urandom_range(1)));
      // cascades, R8
      check_casc(9999, 1, 1'b0);
      check_casc(9999, 0, 1'b1);
      check_casc(9999, 9999, 1'b1);
      check_casc(0, 0, 1'b0);
      check_casc(4567, 5433, 1'b0);
      for (int i = 0; i < 200; i++)
         check_casc(int'($urandom_range(9999)), int'($urandom_range(9999)), 1'($urandom_range(1)));
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule